// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block validates a protected-mode request to load a selector into one of the processor's segment registers. Each request carries the target slot, the 16-bit selector, the current privilege level, the descriptor table limit and the access-rights byte of the descriptor that was fetched. The block runs a fixed, ordered series of checks: null selector, table limit, descriptor type, privilege and presence. It either commits the selector, access byte and a descriptor-valid bit into a shadow register file, or reports the first failing check as a fault class plus an error code.

The stack slot and the four data slots are checked by different rules. A null selector faults when loaded into the stack slot. Loaded into a data slot, it is accepted with its valid bit cleared, so that a later use of that slot can be flagged through the use-check port. A successful stack load opens an interrupt-inhibit window that stays open until the next instruction retires. The code slot is present in the file but is never written by this path.

Top module: `segld_guard`

## Requirements
- R1: `req_ready` is low during reset and high from the first clock after reset. An accepted request (`req_valid` and `req_ready`) gives a one-cycle `done` pulse on the next clock; otherwise `done` is low. When `done` is low, `fault`, `fault_class` and `err_code` are zero. Fault class encoding: 0 = general protection, 1 = stack fault, 2 = not present. After reset every slot except the code slot reads as unusable.
- R2: Slot encoding is 0 = ES, 1 = code slot, 2 = SS, 3 = DS, 4 = FS, 5 = GS. A request naming the code slot or an index above 5 faults with class 0 and code 0 and changes nothing. The use-check port reports the code slot as usable and reports any index above 5 as unusable.
- R3: A selector is null when bits 15:2 are all zero. A null load into SS faults with class 0 and code 0.
- R4: A null load into ES, DS, FS or GS does not fault. It stores the selector, stores an access byte of 0 and clears the slot's valid bit, so the use-check port reports that slot as unusable.
- R5: For a non-null load, if the last byte of the descriptor (the selector with bits 2:0 forced to 1) is greater than the table limit, the load faults with class 0 and the selector as code. A descriptor that ends exactly at the limit passes.
- R6: The access byte is read as follows: bit 7 present, bits 6:5 DPL, bit 4 code/data (must be 1), bit 3 code, bit 2 conforming, bit 1 writable for data or readable for code. An SS load needs bit 4 = 1, bit 3 = 0 and bit 1 = 1; otherwise it faults with class 0 and the selector as code.
- R7: An SS load needs RPL (selector bits 1:0) equal to the CPL and DPL equal to the CPL; otherwise it faults with class 0 and the selector as code.
- R8: An SS load whose descriptor is not present faults with class 1 (stack) and the selector as code.
- R9: A data-slot load needs bit 4 = 1, and either a data descriptor or a code descriptor with bit 1 = 1; otherwise it faults with class 0 and the selector as code.
- R10: For a data descriptor or a non-conforming code descriptor, a data-slot load needs both RPL <= DPL and CPL <= DPL; otherwise it faults with class 0 and the selector as code. A conforming code descriptor skips this check.
- R11: A data-slot load whose descriptor is not present faults with class 2 (not present) and the selector as code.
- R12: The checks are taken in the order null, limit, type, privilege, present, and only the first failure is reported. A fault leaves every slot unchanged. A successful load stores the selector and the full access byte and sets the slot's valid bit; these are visible on the use-check port from the cycle of `done`.
- R13: A successful SS load raises `irq_inhibit` in the cycle of `done`. A cycle with `retire` high and no successful SS load clears the flag at the next clock. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_sreg | input | IDX_W (3) | Target slot index |
| req_sel | input | SEL_W (16) | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_limit | input | LIM_W (16) | Descriptor table limit in bytes |
| req_ar | input | 8 | Access-rights byte of the fetched descriptor |
| retire | input | 1 | An instruction retires this cycle |
| done | output | 1 | Result pulse, one clock after acceptance |
| fault | output | 1 | The request faulted |
| fault_class | output | 2 | Fault class (0 GP, 1 stack, 2 not present) |
| err_code | output | SEL_W (16) | Error code of the fault |
| irq_inhibit | output | 1 | Interrupt-inhibit window after an SS load |
| use_sreg | input | IDX_W (3) | Slot to inspect |
| use_fault | output | 1 | An access through the inspected slot would fault |
| use_sel | output | SEL_W (16) | Stored selector of the inspected slot |
| use_ar | output | 8 | Stored access byte of the inspected slot |

## Verification
The bench builds the block with its default parameters: six slots, a 3-bit slot index, and 16-bit selectors and table limits. With the 3-bit index, codes 6 and 7 are left over, so the out-of-range request path and the out-of-range use-check path can both be driven. With the 16-bit limit, a descriptor ending exactly at the limit and one ending eight bytes past it can both be placed. The stimulus stacks several failing conditions on one request so that the priority order shows in the fault class and error code it reports.

// File: rtl/segld_pkg.sv
package segld_pkg;

   typedef enum logic [1:0] {
      FC_GP = 2'd0,
      FC_SS = 2'd1,
      FC_NP = 2'd2
   } fclass_e;

   // access byte bits 7..1 as seen by the checks
   typedef struct packed {
      logic       present;
      logic [1:0] dpl;
      logic       cd_kind;   // 1 = code/data descriptor
      logic       is_code;
      logic       conf;
      logic       rw;        // writable (data) or readable (code)
   } acc_t;

   typedef struct packed {
      logic    fault;
      fclass_e cls;
      logic    zero_code;
      logic    commit;
      logic    set_valid;
   } verdict_t;

endpackage

// File: rtl/segld_classify.sv
module segld_classify
   import segld_pkg::*;
#(
   parameter int SEL_W    = 16,
   parameter int LIM_W    = 16,
   parameter int NUM_SREG = 6,
   parameter int IDX_W    = 3,
   parameter int SS_IDX   = 2,
   parameter int CS_IDX   = 1
) (
   input  logic [IDX_W-1:0] sreg,
   input  logic [SEL_W-1:0] sel,
   input  logic [1:0]       cpl,
   input  logic [LIM_W-1:0] limit,
   input  acc_t             acc,
   output verdict_t         verdict
);
   localparam logic [IDX_W-1:0] SS_I  = IDX_W'(SS_IDX);
   localparam logic [IDX_W-1:0] CS_I  = IDX_W'(CS_IDX);
   localparam logic [IDX_W:0]   CNT_I = (IDX_W+1)'(NUM_SREG);

   logic [1:0]       rpl;
   logic             is_null;
   logic             is_ss;
   logic             bad_slot;
   logic [LIM_W-1:0] last_byte;
   logic             over_limit;
   logic             ss_type_ok;
   logic             ss_priv_ok;
   logic             ds_type_ok;
   logic             ds_priv_need;
   logic             ds_priv_ok;

   assign rpl        = sel[1:0];
   assign is_null    = (sel[SEL_W-1:2] == '0);
   assign is_ss      = (sreg == SS_I);
   assign bad_slot   = (sreg == CS_I) || ({1'b0, sreg} >= CNT_I);
   assign last_byte  = LIM_W'(sel | SEL_W'(7));
   assign over_limit = (last_byte > limit);

   assign ss_type_ok   = acc.cd_kind && !acc.is_code && acc.rw;
   assign ss_priv_ok   = (rpl == cpl) && (acc.dpl == cpl);
   assign ds_type_ok   = acc.cd_kind && (!acc.is_code || acc.rw);
   assign ds_priv_need = !acc.is_code || !acc.conf;
   assign ds_priv_ok   = !ds_priv_need || ((rpl <= acc.dpl) && (cpl <= acc.dpl));

   always_comb begin
      verdict     = '0;
      verdict.cls = FC_GP;
      if (bad_slot) begin
         verdict.fault     = 1'b1;
         verdict.zero_code = 1'b1;
      end else if (is_null) begin
         if (is_ss) begin
            verdict.fault     = 1'b1;
            verdict.zero_code = 1'b1;
         end else begin
            verdict.commit = 1'b1;
         end
      end else if (over_limit) begin
         verdict.fault = 1'b1;
      end else if (is_ss) begin
         if (!ss_type_ok || !ss_priv_ok) begin
            verdict.fault = 1'b1;
         end else if (!acc.present) begin
            verdict.fault = 1'b1;
            verdict.cls   = FC_SS;
         end else begin
            verdict.commit    = 1'b1;
            verdict.set_valid = 1'b1;
         end
      end else begin
         if (!ds_type_ok || !ds_priv_ok) begin
            verdict.fault = 1'b1;
         end else if (!acc.present) begin
            verdict.fault = 1'b1;
            verdict.cls   = FC_NP;
         end else begin
            verdict.commit    = 1'b1;
            verdict.set_valid = 1'b1;
         end
      end
   end

   always_comb begin
      AST_NULL_SS_FAULTS: assert (!(is_ss && is_null) || (verdict.fault && verdict.zero_code)); // R3
      AST_ONE_OUTCOME: assert (!(verdict.fault && verdict.commit)); // R12
   end

endmodule

// File: rtl/segld_shadow.sv
module segld_shadow #(
   parameter int SEL_W    = 16,
   parameter int NUM_SREG = 6,
   parameter int IDX_W    = 3,
   parameter int CS_IDX   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [7:0]          wr_ar,
   input  logic                wr_valid,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic                rd_fault,
   output logic [SEL_W-1:0]    rd_sel,
   output logic [7:0]          rd_ar,
   output logic [NUM_SREG-1:0] valid_vec
);
   logic [SEL_W-1:0] sel_r [NUM_SREG];
   logic [7:0]       ar_r  [NUM_SREG];

   for (genvar i = 0; i < NUM_SREG; i++) begin : g_slot
      if (i == CS_IDX) begin : g_code
         // the code slot is never written here and always counts as usable
         assign sel_r[i]     = '0;
         assign ar_r[i]      = '0;
         assign valid_vec[i] = 1'b1;
      end else begin : g_data
         logic [SEL_W-1:0] s_q;
         logic [7:0]       a_q;
         logic             v_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s_q <= '0;
               a_q <= '0;
               v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
               s_q <= wr_sel;
               a_q <= wr_ar;
               v_q <= wr_valid;
            end
         end
         assign sel_r[i]     = s_q;
         assign ar_r[i]      = a_q;
         assign valid_vec[i] = v_q;

         AST_CODE_SLOT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(CS_IDX)))); // R2
      end
   end

   always_comb begin
      rd_fault = 1'b1;
      rd_sel   = '0;
      rd_ar    = '0;
      for (int k = 0; k < NUM_SREG; k++) begin
         if (rd_idx == IDX_W'(k)) begin
            rd_fault = !valid_vec[k];
            rd_sel   = sel_r[k];
            rd_ar    = ar_r[k];
         end
      end
   end

endmodule

// File: rtl/segld_inhibit.sv
module segld_inhibit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic retire,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set)    flag <= 1'b1;
      else if (retire) flag <= 1'b0;
   end

   AST_INHIBIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag); // R13
   AST_INHIBIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && retire) |=> !flag); // R13

endmodule

// File: rtl/segld_guard.sv
module segld_guard
   import segld_pkg::*;
#(
   parameter int SEL_W    = 16,
   parameter int LIM_W    = 16,
   parameter int NUM_SREG = 6,
   parameter int SS_IDX   = 2,
   parameter int CS_IDX   = 1,
   parameter int IDX_W    = $clog2(NUM_SREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [IDX_W-1:0] req_sreg,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [1:0]       req_cpl,
   input  logic [LIM_W-1:0] req_limit,
   input  logic [7:0]       req_ar,
   input  logic             retire,
   output logic             done,
   output logic             fault,
   output logic [1:0]       fault_class,
   output logic [SEL_W-1:0] err_code,
   output logic             irq_inhibit,
   input  logic [IDX_W-1:0] use_sreg,
   output logic             use_fault,
   output logic [SEL_W-1:0] use_sel,
   output logic [7:0]       use_ar
);
   localparam logic [IDX_W-1:0] SS_I = IDX_W'(SS_IDX);

   if (SEL_W < 4) begin : g_bad_sel
      $error("segld_guard: SEL_W must leave room for an index field");
   end
   if (LIM_W < SEL_W) begin : g_bad_lim
      $error("segld_guard: LIM_W must be at least SEL_W");
   end
   if (SS_IDX == CS_IDX || SS_IDX >= NUM_SREG || CS_IDX >= NUM_SREG) begin : g_bad_idx
      $error("segld_guard: slot indices out of range or overlapping");
   end
   if ((1 << IDX_W) < NUM_SREG) begin : g_bad_w
      $error("segld_guard: IDX_W too narrow for NUM_SREG");
   end

   logic                ready_q;
   logic                accept;
   verdict_t            verdict;
   logic                wr_en;
   logic [NUM_SREG-1:0] valid_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end
   assign req_ready = ready_q;
   assign accept    = req_valid && ready_q;

   segld_classify #(
      .SEL_W(SEL_W), .LIM_W(LIM_W), .NUM_SREG(NUM_SREG),
      .IDX_W(IDX_W), .SS_IDX(SS_IDX), .CS_IDX(CS_IDX)
   ) i_classify (
      .sreg   (req_sreg),
      .sel    (req_sel),
      .cpl    (req_cpl),
      .limit  (req_limit),
      .acc    (acc_t'(req_ar[7:1])),
      .verdict(verdict)
   );

   assign wr_en = accept && verdict.commit;

   segld_shadow #(
      .SEL_W(SEL_W), .NUM_SREG(NUM_SREG), .IDX_W(IDX_W), .CS_IDX(CS_IDX)
   ) i_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (req_sreg),
      .wr_sel   (req_sel),
      .wr_ar    (verdict.set_valid ? req_ar : 8'h00),
      .wr_valid (verdict.set_valid),
      .rd_idx   (use_sreg),
      .rd_fault (use_fault),
      .rd_sel   (use_sel),
      .rd_ar    (use_ar),
      .valid_vec(valid_vec)
   );

   segld_inhibit i_inhibit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wr_en && (req_sreg == SS_I)),
      .retire(retire),
      .flag  (irq_inhibit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done        <= 1'b0;
         fault       <= 1'b0;
         fault_class <= 2'd0;
         err_code    <= '0;
      end else begin
         done        <= accept;
         fault       <= accept && verdict.fault;
         fault_class <= (accept && verdict.fault) ? verdict.cls : 2'd0;
         err_code    <= (accept && verdict.fault && !verdict.zero_code) ? req_sel : '0;
      end
   end

   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> done); // R1
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> (!done && !fault)); // R1
   AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_class != 2'd3)); // R1
   AST_SS_NULL_GP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_sreg == SS_I) && (req_sel[SEL_W-1:2] == '0))
      |=> (fault && (fault_class == 2'd0) && (err_code == '0))); // R3
   AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> $stable(valid_vec)); // R12
   AST_SS_LOAD_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && ($past(req_sreg) == SS_I)) |-> irq_inhibit); // R13

endmodule

// File: tb/test_segld_guard.sv
module test_segld_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_sreg = '0;
   logic [15:0] req_sel = '0;
   logic [1:0]  req_cpl = '0;
   logic [15:0] req_limit = '0;
   logic [7:0]  req_ar = '0;
   logic        retire = 1'b0;
   logic        done, fault;
   logic [1:0]  fault_class;
   logic [15:0] err_code;
   logic        irq_inhibit;
   logic [2:0]  use_sreg = '0;
   logic        use_fault;
   logic [15:0] use_sel;
   logic [7:0]  use_ar;

   always #5 clk = ~clk;

   segld_guard i_segld_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sreg(req_sreg), .req_sel(req_sel), .req_cpl(req_cpl),
      .req_limit(req_limit), .req_ar(req_ar), .retire(retire),
      .done(done), .fault(fault), .fault_class(fault_class), .err_code(err_code),
      .irq_inhibit(irq_inhibit), .use_sreg(use_sreg), .use_fault(use_fault),
      .use_sel(use_sel), .use_ar(use_ar)
   );

   int    n_run = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   // reference model state
   int m_sel [6];
   int m_ar  [6];
   bit m_valid [6];
   bit m_inh;
   bit e_ready, e_done, e_fault;
   int e_cls, e_code;

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void ref_eval(input int s, input int sel, input int cpl,
                                    input int lim, input int ar,
                                    output bit f, output int cls, output int code,
                                    output bit wr, output bit val);
      int  rpl = sel & 3;
      int  dpl = (ar >> 5) & 3;
      bit  pres = ar[7];
      bit  cdk = ar[4];
      bit  cod = ar[3];
      bit  cnf = ar[2];
      bit  rw = ar[1];
      f = 0; cls = 0; code = 0; wr = 0; val = 0;
      if (s == 1 || s > 5) begin f = 1; return; end
      if ((sel >> 2) == 0) begin
         if (s == 2) f = 1;
         else wr = 1;
         return;
      end
      if ((sel | 7) > lim) begin f = 1; code = sel; return; end
      if (s == 2) begin
         if (!cdk || cod || !rw)           begin f = 1; code = sel; return; end
         if (rpl != cpl || dpl != cpl)     begin f = 1; code = sel; return; end
         if (!pres)                        begin f = 1; cls = 1; code = sel; return; end
      end else begin
         if (!cdk || (cod && !rw))         begin f = 1; code = sel; return; end
         if ((!cod || !cnf) && (rpl > dpl || cpl > dpl)) begin f = 1; code = sel; return; end
         if (!pres)                        begin f = 1; cls = 2; code = sel; return; end
      end
      wr = 1; val = 1;
   endfunction

   // model advances on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin m_sel[i] = 0; m_ar[i] = 0; m_valid[i] = 0; end
         m_inh = 0; e_ready = 0; e_done = 0; e_fault = 0; e_cls = 0; e_code = 0;
      end else begin
         bit f, wr, val;
         int cls, code;
         bit ss_set;
         ss_set = 0;
         e_done = req_valid && e_ready;
         e_fault = 0; e_cls = 0; e_code = 0;
         if (e_done) begin
            ref_eval(int'(req_sreg), int'(req_sel), int'(req_cpl), int'(req_limit),
                     int'(req_ar), f, cls, code, wr, val);
            e_fault = f; e_cls = cls; e_code = code;
            if (wr) begin
               m_sel[req_sreg] = int'(req_sel);
               m_ar[req_sreg] = val ? int'(req_ar) : 0;
               m_valid[req_sreg] = val;
               if (req_sreg == 3'd2) ss_set = 1;
            end
         end
         if (ss_set) m_inh = 1;
         else if (retire) m_inh = 0;
         e_ready = 1;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur_req, " R1 ready"}, int'(req_ready), int'(e_ready));
         chk({cur_req, " R1 done"}, int'(done), int'(e_done));
         chk({cur_req, " fault"}, int'(fault), int'(e_fault));
         chk({cur_req, " class"}, int'(fault_class), e_cls);
         chk({cur_req, " code"}, int'(err_code), e_code);
         chk({cur_req, " R13 inhibit"}, int'(irq_inhibit), int'(m_inh));
      end
   end

   task automatic req(string r, int s, int sel, int cpl, int lim, int ar);
      @(negedge clk);
      cur_req = r;
      req_sreg = 3'(s); req_sel = 16'(sel); req_cpl = 2'(cpl);
      req_limit = 16'(lim); req_ar = 8'(ar); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic peek_all(string r);
      for (int k = 0; k < 8; k++) begin
         bit ef;
         int es, ea;
         use_sreg = 3'(k);
         #1;
         ef = (k == 1) ? 0 : (k > 5) ? 1 : !m_valid[k];
         es = (k < 6) ? m_sel[k] : 0;
         ea = (k < 6) ? m_ar[k] : 0;
         chk({r, " use_fault"}, int'(use_fault), int'(ef));
         chk({r, " use_sel"}, int'(use_sel), es);
         chk({r, " use_ar"}, int'(use_ar), ea);
      end
   endtask

   task automatic pulse_retire();
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      peek_all("R1 reset");
      // R12 successful data load
      req("R12", 3, 16'h0010, 0, 16'h00FF, 8'h92);
      peek_all("R12 commit");
      req("R3", 2, 16'h0002, 0, 16'h00FF, 8'h92);
      req("R4", 3, 16'h0003, 0, 16'h00FF, 8'h92);
      peek_all("R4 null data");
      req("R5", 0, 16'h0100, 0, 16'h00FF, 8'h92);
      req("R5", 0, 16'h00F8, 0, 16'h00FF, 8'h92);
      peek_all("R5 boundary");
      req("R6", 2, 16'h0010, 0, 16'h00FF, 8'h9A);
      req("R6", 2, 16'h0010, 0, 16'h00FF, 8'h90);
      req("R7", 2, 16'h0011, 0, 16'h00FF, 8'h92);
      req("R7", 2, 16'h0010, 0, 16'h00FF, 8'hB2);
      req("R8", 2, 16'h0018, 0, 16'h00FF, 8'h12);
      req("R12", 2, 16'h0032, 1, 16'h00FF, 8'h32);
      req("R13", 2, 16'h0018, 0, 16'h00FF, 8'h92);
      peek_all("R13 ss commit");
      pulse_retire();
      req("R13", 2, 16'h0020, 0, 16'h00FF, 8'h92);
      @(negedge clk); retire = 1'b1;
      cur_req = "R13";
      req_sreg = 3'd2; req_sel = 16'h0028; req_cpl = 2'd0;
      req_limit = 16'h00FF; req_ar = 8'h92; req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0; retire = 1'b0;
      pulse_retire();
      req("R9", 3, 16'h0010, 0, 16'h00FF, 8'h98);
      req("R9", 4, 16'h0010, 0, 16'h00FF, 8'h82);
      req("R10", 0, 16'h0023, 3, 16'h00FF, 8'h9E);
      req("R10", 4, 16'h0020, 3, 16'h00FF, 8'h92);
      req("R10", 5, 16'h002B, 0, 16'h00FF, 8'h92);
      req("R10", 5, 16'h0033, 3, 16'h00FF, 8'hF2);
      req("R11", 5, 16'h0030, 0, 16'h00FF, 8'h12);
      req("R12", 4, 16'h0400, 0, 16'h00FF, 8'h12);
      req("R2", 1, 16'h0010, 0, 16'h00FF, 8'h9A);
      req("R2", 6, 16'h0010, 0, 16'h00FF, 8'h92);
      req("R2", 7, 16'h0000, 0, 16'h00FF, 8'h92);
      peek_all("R12 final");
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule